// File: doc/BRIEF.md
# SPI Register Bank Interface

This block is a serial slave that lets an external host reach a small bank of 24-bit registers over a four-wire SPI link. The SPI clock, select and data-in lines are sampled in the system clock domain and never used as clocks. Each transfer starts with a command byte. The command byte names a device, a register and a direction. One or more 24-bit words follow, most significant bit first. Data moves in only one direction at a time. Reads drive the serial output only during their data phase, and an enable output lets the pad go to high impedance at all other times.

The bank has two kinds of register. The low addresses are read-only words taken from a parallel input port. The next addresses are configuration words, writable by the host and presented on a parallel output port. All other addresses read as zero and ignore writes. When the select line stays low after a word, the register address advances and the next word streams out or in, wrapping from the top address to zero. Both SPI mode 0,0 and mode 1,1 work, because input bits are taken on rising SCK and output bits change on falling SCK.

The controller has five states:
- `LS_IDLE`: the link is unselected.
- `LS_CTRL`: the 8 command bits are being shifted in.
- `LS_WRITE`: 24-bit words are received and committed.
- `LS_READ`: 24-bit words are shifted out.
- `LS_IGNORE`: the device field did not match, and the rest of the transfer is dropped.

The transitions are:
- `LS_IDLE`→`LS_CTRL` on a select falling edge.
- `LS_CTRL`→`LS_READ`, `LS_WRITE` or `LS_IGNORE` on the eighth rising SCK, chosen by the command byte.
- Any state→`LS_IDLE` while select is high.

Top module: `spi_regbank`

## Requirements
- R1: While `rst_n` is low, all configuration words are zero, `spi_dout_en` is 0 and any transfer in progress is abandoned.
- R2: A falling edge of `spi_sel_n` starts a transfer. Select high ends it, and a partially received word is discarded without any register change.
- R3: The first 8 bits after select falls form the command byte, taken MSB first on rising SCK. Bits [7:6] are the device field, bits [5:1] are the register address, and bit 0 is 1 for a read and 0 for a write.
- R4: If the device field differs from `dev_sel`, the transfer changes no register and `spi_dout_en` stays 0.
- R5: A write shifts in 24 bits MSB first on rising SCK. Only after the 24th bit is configuration word k (address DATA_REGS+k, 6..11 by default) updated, on `cfg_words[24k+23:24k]`.
- R6: A read shifts out 24 bits MSB first. Each bit changes on a falling SCK, and the first bit appears on the first falling edge after the command byte.
- R7: `spi_dout_en` is 0 during the command byte, during an entire write, and while select is high. It is 1 during the data phase of a matched read.
- R8: While select stays low, the address increments after each 24-bit word and wraps from 31 to 0.
- R9: Address i < DATA_REGS reads `sample_words[24i+23:24i]`. Addresses at or above DATA_REGS+CFG_REGS read as zero. Writes to either range are ignored.
- R10: The value read for a word is captured at the first falling SCK of that word, so later changes of `sample_words` do not alter it.
- R11: Toggling `spi_din` during a read's data phase has no effect on any register.
- R12: Both SCK idle-low (mode 0,0) and SCK idle-high (mode 1,1) transfers read and write correctly.
- R13: An SCK or select edge takes effect at the third rising `clk` edge after it: two synchronizer stages plus one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk | input | 1 | SPI serial clock from host |
| spi_sel_n | input | 1 | SPI select, active low |
| spi_din | input | 1 | Serial data from host |
| dev_sel | input | DEV_W (2) | Strap value the device field must equal |
| sample_words | input | DATA_REGS*24 (144) | Read-only data words, word i at bits [24i+23:24i] |
| spi_dout | output | 1 | Serial data to host |
| spi_dout_en | output | 1 | Output enable for the serial data pad |
| cfg_words | output | CFG_REGS*24 (144) | Configuration words, word k at bits [24k+23:24k] |

## Verification
Every SPI pin edge is driven on a falling `clk` edge. Its effect is due at the third rising `clk` edge after it: a configuration update after the 24th rising SCK of a word, the enable rising after the eighth command bit, and the enable falling after select rises. The bench pushes each expected effect through its own three-stage delay line and compares enable and configuration outputs on every falling `clk` edge. Serial output bits are sampled just before the bench raises SCK, four `clk` periods after the preceding falling SCK, which is later than the three edges the design needs to present the bit.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    // Link controller states.
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_CTRL,
        LS_WRITE,
        LS_READ,
        LS_IGNORE
    } link_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
module spi_pin_sync #(
    parameter int N = 1,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] pin_q
);

    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= pin;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_link_fsm.sv
// Command decoding, bit counting and serial shifting for the register link.
module spi_link_fsm
    import spi_regbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DEV_W  = 2,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_q,
    input  logic              sel_q,
    input  logic              din_q,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en
);

    localparam int CMD_W   = DEV_W + ADDR_W + 1;
    localparam int MAX_LEN = (WORD_W > CMD_W) ? WORD_W : CMD_W;
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    link_state_t       state_q, state_d;
    logic              sck_prev, sel_prev;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shift_in;
    logic [WORD_W-1:0] rd_shift;
    logic [ADDR_W-1:0] addr_q;
    logic              dout_q;

    logic             sck_rise, sck_fall, sel_fall;
    logic [CMD_W-1:0] cmd_byte;
    logic             dev_ok;

    assign sck_rise = sck_q & ~sck_prev;
    assign sck_fall = ~sck_q & sck_prev;
    assign sel_fall = ~sel_q & sel_prev;
    assign cmd_byte = {shift_in[CMD_W-2:0], din_q};
    assign dev_ok   = (cmd_byte[CMD_W-1 -: DEV_W] == dev_sel);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (sel_fall) state_d = LS_CTRL;
            end
            LS_CTRL: begin
                if (sel_q) begin
                    state_d = LS_IDLE;
                end else if (sck_rise && bit_cnt == CMD_LAST) begin
                    if (!dev_ok)          state_d = LS_IGNORE;
                    else if (cmd_byte[0]) state_d = LS_READ;
                    else                  state_d = LS_WRITE;
                end
            end
            LS_WRITE, LS_READ, LS_IGNORE: begin
                if (sel_q) state_d = LS_IDLE;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    // Counters, shifters and address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            sel_prev <= 1'b1;
            bit_cnt  <= '0;
            shift_in <= '0;
            rd_shift <= '0;
            addr_q   <= '0;
            dout_q   <= 1'b0;
        end else begin
            sck_prev <= sck_q;
            sel_prev <= sel_q;
            if (state_q == LS_IDLE || sel_q) begin
                bit_cnt <= '0;
            end else begin
                unique case (state_q)
                    LS_CTRL: begin
                        if (sck_rise) begin
                            shift_in <= {shift_in[WORD_W-3:0], din_q};
                            if (bit_cnt == CMD_LAST) begin
                                bit_cnt <= '0;
                                addr_q  <= cmd_byte[ADDR_W:1];
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    LS_WRITE: begin
                        if (sck_rise) begin
                            shift_in <= {shift_in[WORD_W-3:0], din_q};
                            if (bit_cnt == WORD_LAST) begin
                                bit_cnt <= '0;
                                addr_q  <= addr_q + 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    LS_READ: begin
                        if (sck_fall) begin
                            if (bit_cnt == '0) begin
                                dout_q   <= rd_word[WORD_W-1];
                                rd_shift <= {rd_word[WORD_W-2:0], 1'b0};
                            end else begin
                                dout_q   <= rd_shift[WORD_W-1];
                                rd_shift <= {rd_shift[WORD_W-2:0], 1'b0};
                            end
                            if (bit_cnt == WORD_LAST) begin
                                bit_cnt <= '0;
                                addr_q  <= addr_q + 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs.
    always_comb begin
        wr_en    = (state_q == LS_WRITE) && !sel_q && sck_rise && (bit_cnt == WORD_LAST);
        wr_data  = {shift_in, din_q};
        reg_addr = addr_q;
        dout_en  = (state_q == LS_READ);
        dout     = dout_en ? dout_q : 1'b0;
    end

    // R7
    oe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |=> !dout_en);

    // R7
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(state_q) == LS_CTRL);

    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_READ && !sck_fall) |=> $stable(dout_q));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

endmodule

// File: rtl/spi_reg_bank.sv
// Read-only sample words, writable configuration words and read multiplexer.
module spi_reg_bank #(
    parameter int DATA_REGS = 6,
    parameter int CFG_REGS  = 6,
    parameter int WORD_W    = 24,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_REGS*WORD_W-1:0] sample_words,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           rd_word,
    output logic [CFG_REGS*WORD_W-1:0]  cfg_words
);

    localparam int CFG_BASE = DATA_REGS;
    localparam int CFG_END  = DATA_REGS + CFG_REGS;

    for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + k);
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            word_q <= '0;
            else if (wr_en && reg_addr == MY_ADDR) word_q <= wr_data;
        end

        assign cfg_words[k*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DATA_REGS; i++) begin
            if (reg_addr == ADDR_W'(i)) rd_word = sample_words[i*WORD_W +: WORD_W];
        end
        for (int k = 0; k < CFG_REGS; k++) begin
            if (reg_addr == ADDR_W'(CFG_BASE + k)) rd_word = cfg_words[k*WORD_W +: WORD_W];
        end
    end

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(reg_addr) < CFG_BASE || int'(reg_addr) >= CFG_END))
        |=> $stable(cfg_words));

endmodule

// File: rtl/spi_regbank.sv
// Top level: pin synchronizers, link controller and register bank.
module spi_regbank #(
    parameter int DATA_REGS   = 6,
    parameter int CFG_REGS    = 6,
    parameter int WORD_W      = 24,
    parameter int ADDR_W      = 5,
    parameter int DEV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_clk,
    input  logic                        spi_sel_n,
    input  logic                        spi_din,
    input  logic [DEV_W-1:0]            dev_sel,
    input  logic [DATA_REGS*WORD_W-1:0] sample_words,
    output logic                        spi_dout,
    output logic                        spi_dout_en,
    output logic [CFG_REGS*WORD_W-1:0]  cfg_words
);

    logic [2:0]        pins_q;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_word;

    // Bit order: {din, sel_n, sck}; select idles high.
    spi_pin_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({spi_din, spi_sel_n, spi_clk}),
        .pin_q (pins_q)
    );

    spi_link_fsm #(
        .ADDR_W (ADDR_W),
        .DEV_W  (DEV_W),
        .WORD_W (WORD_W)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_q    (pins_q[0]),
        .sel_q    (pins_q[1]),
        .din_q    (pins_q[2]),
        .dev_sel  (dev_sel),
        .rd_word  (rd_word),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .dout     (spi_dout),
        .dout_en  (spi_dout_en)
    );

    spi_reg_bank #(
        .DATA_REGS (DATA_REGS),
        .CFG_REGS  (CFG_REGS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_words (sample_words),
        .wr_en        (wr_en),
        .reg_addr     (reg_addr),
        .wr_data      (wr_data),
        .rd_word      (rd_word),
        .cfg_words    (cfg_words)
    );

endmodule

// File: tb/spi_regbank_tb.sv
module spi_regbank_tb;

    localparam int NDATA = 6;
    localparam int NCFG  = 6;
    localparam int HALF  = 4;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sel_n = 1'b1, din = 1'b0;
    logic [NDATA*24-1:0] samples;
    logic dout, dout_en;
    logic [NCFG*24-1:0] cfg;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_regbank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_clk      (sck),
        .spi_sel_n    (sel_n),
        .spi_din      (din),
        .dev_sel      (STRAP),
        .sample_words (samples),
        .spi_dout     (dout),
        .spi_dout_en  (dout_en),
        .cfg_words    (cfg)
    );

    // Reference model: expected effects delayed three rising clk edges (R13).
    logic        wr_int_v = 1'b0;
    logic [4:0]  wr_int_a = '0;
    logic [23:0] wr_int_d = '0;
    logic        oe_int = 1'b0;
    logic [1:0]  wv_p, oe_p;
    logic [4:0]  wa0, wa1;
    logic [23:0] wd0, wd1;
    logic        exp_oe;
    logic [NCFG*24-1:0] model_cfg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wv_p <= '0; oe_p <= '0; exp_oe <= 1'b0; model_cfg <= '0;
            wa0 <= '0; wa1 <= '0; wd0 <= '0; wd1 <= '0;
        end else begin
            wv_p <= {wv_p[0], wr_int_v};
            wa0 <= wr_int_a; wa1 <= wa0;
            wd0 <= wr_int_d; wd1 <= wd0;
            if (wv_p[1]) model_cfg[(int'(wa1) - NDATA)*24 +: 24] <= wd1;
            oe_p <= {oe_p[0], oe_int};
            exp_oe <= oe_p[1];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [NCFG*24-1:0] act,
                       input logic [NCFG*24-1:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Per-clock comparison (R7 R5 R13).
    always @(negedge clk) begin
        chk(dout_en === exp_oe, "R7 R13 dout_en", {{(NCFG*24-1){1'b0}}, dout_en},
            {{(NCFG*24-1){1'b0}}, exp_oe});
        chk(cfg === model_cfg, "R5 R13 cfg_words", cfg, model_cfg);
    end

    function automatic logic [23:0] exp_read(input logic [4:0] a);
        if (int'(a) < NDATA) return samples[int'(a)*24 +: 24];
        if (int'(a) < NDATA + NCFG) return model_cfg[(int'(a) - NDATA)*24 +: 24];
        return 24'h0;
    endfunction

    logic [23:0] tx_words [4];

    // One SCK period; called and returning on a falling clk edge.
    task automatic clock_bit(input bit cpol, input logic b, input bit last_wr,
                             input bit oe_on, output logic seen);
        if (cpol) sck = 1'b0;
        din = b;
        repeat (HALF) @(negedge clk);
        seen = dout;
        sck = 1'b1;
        if (last_wr) wr_int_v = 1'b1;
        if (oe_on) oe_int = 1'b1;
        @(negedge clk);
        wr_int_v = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        if (!cpol) sck = 1'b0;
    endtask

    task automatic xfer(input bit cpol, input logic [1:0] dev, input logic [4:0] addr,
                        input bit rd, input int nwords, input int abort_bits, input string req);
        logic [7:0] cmd;
        logic [4:0] a;
        logic [23:0] expw, got;
        logic seen;
        bit match, stop;
        int cnt;
        cmd = {dev, addr, rd};
        match = (dev == STRAP);
        stop = 1'b0;
        cnt = 0;
        @(negedge clk);
        sck = cpol;
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            clock_bit(cpol, cmd[7-i], 1'b0, (i == 7) && rd && match, seen);
        end
        a = addr;
        for (int w = 0; w < nwords && !stop; w++) begin
            expw = rd ? exp_read(a) : tx_words[w];
            got = '0;
            for (int b = 0; b < 24 && !stop; b++) begin
                if (abort_bits >= 0 && cnt == abort_bits) begin
                    stop = 1'b1;
                end else begin
                    wr_int_a = a;
                    wr_int_d = tx_words[w];
                    clock_bit(cpol, rd ? logic'(b % 2) : tx_words[w][23-b],
                              !rd && match && b == 23 && int'(a) >= NDATA && int'(a) < NDATA + NCFG,
                              1'b0, seen);
                    got = {got[22:0], seen};
                    cnt++;
                end
            end
            if (rd && match && !stop) begin
                chk(got === expw, req, {120'h0, got}, {120'h0, expw});
            end
            a = a + 1'b1;
        end
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        oe_int = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic seen;
        logic [NCFG*24-1:0] snap;
        for (int i = 0; i < NDATA; i++) samples[i*24 +: 24] = 24'hA10000 + 24'(i * 24'h000F11);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cfg === '0, "R1 reset cfg", cfg, '0);
        chk(dout_en === 1'b0, "R1 reset oe", {143'h0, dout_en}, '0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 R5: single write to configuration word 0 (address 6)
        tx_words[0] = 24'h123456;
        xfer(1'b0, STRAP, 5'd6, 1'b0, 1, -1, "R5 write");
        chk(cfg[23:0] === 24'h123456, "R5 cfg word0", {120'h0, cfg[23:0]}, {120'h0, 24'h123456});
        // R6: read it back
        xfer(1'b0, STRAP, 5'd6, 1'b1, 1, -1, "R6 read cfg");
        // R9: read a sample word
        xfer(1'b0, STRAP, 5'd2, 1'b1, 1, -1, "R9 read sample");
        // R8: burst write 7..9
        tx_words[0] = 24'hF00001; tx_words[1] = 24'h0FF002; tx_words[2] = 24'h800003;
        xfer(1'b0, STRAP, 5'd7, 1'b0, 3, -1, "R8 burst write");
        chk(cfg[95:24] === {24'h800003, 24'h0FF002, 24'hF00001}, "R8 burst cfg",
            {72'h0, cfg[95:24]}, {72'h0, 24'h800003, 24'h0FF002, 24'hF00001});
        // R8 R9: burst read across wrap 30,31,0,1 (30,31 unmapped read zero)
        xfer(1'b0, STRAP, 5'd30, 1'b1, 4, -1, "R8 R9 wrap read");
        xfer(1'b0, STRAP, 5'd5, 1'b1, 4, -1, "R8 sample-to-cfg read");
        // R4: device mismatch write and read
        snap = cfg;
        tx_words[0] = 24'hDEAD01;
        xfer(1'b0, 2'b01, 5'd10, 1'b0, 1, -1, "R4 mismatch write");
        xfer(1'b0, 2'b11, 5'd10, 1'b1, 1, -1, "R4 mismatch read");
        chk(cfg === snap, "R4 no change", cfg, snap);
        // R9: writes to read-only and unmapped addresses ignored
        tx_words[0] = 24'h5A5A5A;
        xfer(1'b0, STRAP, 5'd1, 1'b0, 1, -1, "R9 ro write");
        xfer(1'b0, STRAP, 5'd20, 1'b0, 1, -1, "R9 unmapped write");
        chk(cfg === snap, "R9 cfg unchanged", cfg, snap);
        xfer(1'b0, STRAP, 5'd1, 1'b1, 1, -1, "R9 ro readback");
        // R2: write aborted after 12 data bits
        tx_words[0] = 24'h777777;
        xfer(1'b0, STRAP, 5'd11, 1'b0, 1, 12, "R2 abort");
        chk(cfg === snap, "R2 partial discarded", cfg, snap);
        // R12: mode 1,1 write and read
        tx_words[0] = 24'hC3A5E1;
        xfer(1'b1, STRAP, 5'd11, 1'b0, 1, -1, "R12 mode11 write");
        chk(cfg[143:120] === 24'hC3A5E1, "R12 mode11 cfg", {120'h0, cfg[143:120]},
            {120'h0, 24'hC3A5E1});
        xfer(1'b1, STRAP, 5'd10, 1'b1, 2, -1, "R12 mode11 read");
        sck = 1'b0;
        // R10: sample word changes mid-word; captured value expected
        fork
            xfer(1'b0, STRAP, 5'd3, 1'b1, 1, -1, "R10 capture");
            begin
                repeat (8 * 2 * HALF + 10 * 2 * HALF) @(negedge clk);
                samples[3*24 +: 24] = 24'h0BEEF0;
            end
        join
        xfer(1'b0, STRAP, 5'd3, 1'b1, 1, -1, "R10 new value");
        // R11: din toggles during read data, registers untouched
        snap = cfg;
        xfer(1'b0, STRAP, 5'd6, 1'b1, 3, -1, "R11 read");
        chk(cfg === snap, "R11 no effect", cfg, snap);
        // R1: reset during a write transfer
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 18; i++) clock_bit(1'b0, logic'(i % 3 == 0), 1'b0, 1'b0, seen);
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cfg === '0, "R1 mid reset cfg", cfg, '0);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (6) @(negedge clk);
        tx_words[0] = 24'h00C0DE;
        xfer(1'b0, STRAP, 5'd8, 1'b0, 1, -1, "R1 write after reset");
        chk(cfg[71:48] === 24'h00C0DE, "R1 post-reset write", {120'h0, cfg[71:48]},
            {120'h0, 24'h00C0DE});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule